// File: doc/BRIEF.md
# Temperature-indexed lookup DAC sequencer

This block produces two 8-bit converter codes, one per output channel, from two separate 64-entry lookup tables. One temperature ADC serves both channels. Its 8-bit result is reduced to a 6-bit table index, the upper six bits of the code. Each channel can replace that index with a 6-bit address of its own. It can also ignore its table and drive an 8-bit value straight to its converter.

After reset the block holds both converter codes at zero until a usable temperature reading exists. With the averaging filter bypassed, one valid sample ends the hold. With the filter active, the index comes from the truncated mean of four consecutive valid samples, and the hold ends only after the fourth one. The table storage sits outside the block. The block presents an address on each channel's read port and takes back the entry one clock later.

Top module: `lut_dac_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, both `dac_code` channels are 00h and each `tbl_addr` channel is its direct address if that channel's `tbl_dir_en` bit is 1, otherwise 0.
- R2: Both `dac_code` channels stay 00h until the hold is released, whatever the direct-value controls are.
- R3: With `filt_off` = 1, the hold ends after one valid sample: from the second clock edge after the edge that takes the sample, the DAC codes follow their sources.
- R4: With `filt_off` = 0, three valid samples do not end the hold; the fourth does, with the same two-edge delay as R3.
- R5: The ADC index is bits [7:2] of the latest sample when `filt_off` = 1. When `filt_off` = 0 it is bits [7:2] of floor(sum of four consecutive valid samples / 4), updated once every fourth sample.
- R6: Channel i's `tbl_addr` field (bits [6i+5:6i]) equals its `tbl_dir_addr` field when `tbl_dir_en[i]` = 1, otherwise the ADC index.
- R7: After release, when `dac_dir_en[i]` = 1, channel i's `dac_code` field (bits [8i+7:8i]) equals that channel's `dac_dir_val` field from the previous cycle.
- R8: After release, when `dac_dir_en[i]` = 0, channel i's `dac_code` equals that channel's `tbl_data` field from the previous cycle. The table returns the entry for the address presented one cycle before that.
- R9: The controls of one channel have no effect on the address or code of the other.
- R10: An `adc_code` value presented with `adc_valid` = 0 is ignored: the index, the averaging progress and the hold do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_valid | input | 1 | Marks a new ADC sample on adc_code |
| adc_code | input | 8 | Temperature ADC sample |
| filt_off | input | 1 | 1 = single-sample mode, 0 = four-sample averaging |
| tbl_dir_en | input | 2 | Per channel: address table from tbl_dir_addr |
| tbl_dir_addr | input | 12 | Per channel 6-bit direct table address |
| dac_dir_en | input | 2 | Per channel: drive DAC from dac_dir_val |
| dac_dir_val | input | 16 | Per channel 8-bit direct DAC value |
| tbl_addr | output | 12 | Per channel table read address |
| tbl_data | input | 16 | Per channel table entry, one cycle after address |
| dac_code | output | 16 | Per channel DAC input code |

## Verification
The bench uses the default parameters: two channels, 8-bit codes, 6-bit table addresses and an averaging window of four samples. Random ADC codes then reach all 64 entries of each table, and the averaging counter wraps through its whole window many times. Each mode is brought up from reset, so the hold release at the first sample and at the fourth sample are both exercised against a reference model.

// File: rtl/lds_pkg.sv
package lds_pkg;
    localparam int CODE_W_DEF   = 8;
    localparam int ADDR_W_DEF   = 6;
    localparam int AVG_LOG2_DEF = 2;
    localparam int NCH_DEF      = 2;
endpackage

// File: rtl/lds_sampler.sv
module lds_sampler #(
    parameter int CODE_W   = lds_pkg::CODE_W_DEF,
    parameter int ADDR_W   = lds_pkg::ADDR_W_DEF,
    parameter int AVG_LOG2 = lds_pkg::AVG_LOG2_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adc_valid,
    input  logic [CODE_W-1:0] adc_code,
    input  logic              filt_off,
    output logic [ADDR_W-1:0] idx_q,
    output logic              ok_q
);
    localparam int ACC_W   = CODE_W + AVG_LOG2;
    localparam int CNT_MAX = (1 << AVG_LOG2) - 1;

    typedef struct packed {
        logic [ACC_W-1:0]    acc;
        logic [AVG_LOG2-1:0] cnt;
        logic [ADDR_W-1:0]   idx;
        logic                ok;
    } samp_t;

    samp_t s_d, s_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        s_d = s_q;
        sum = s_q.acc + ACC_W'(adc_code);
        if (adc_valid) begin
            if (filt_off) begin
                s_d.idx = ADDR_W'(adc_code >> (CODE_W - ADDR_W));
                s_d.ok  = 1'b1;
                s_d.acc = '0;
                s_d.cnt = '0;
            end else if (s_q.cnt == AVG_LOG2'(CNT_MAX)) begin
                s_d.idx = ADDR_W'(sum >> (ACC_W - ADDR_W));
                s_d.ok  = 1'b1;
                s_d.acc = '0;
                s_d.cnt = '0;
            end else begin
                s_d.acc = sum;
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign idx_q = s_q.idx;
    assign ok_q  = s_q.ok;
endmodule

// File: rtl/lds_channel.sv
module lds_channel #(
    parameter int CODE_W = lds_pkg::CODE_W_DEF,
    parameter int ADDR_W = lds_pkg::ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rel,
    input  logic [ADDR_W-1:0] adc_idx,
    input  logic              tdir_en,
    input  logic [ADDR_W-1:0] tdir_addr,
    input  logic              ddir_en,
    input  logic [CODE_W-1:0] ddir_val,
    input  logic [CODE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CODE_W-1:0] dac_q
);
    typedef struct packed {
        logic [CODE_W-1:0] dac;
    } chan_t;

    chan_t c_d, c_q;

    always_comb begin
        rd_addr = tdir_en ? tdir_addr : adc_idx;
        c_d     = c_q;
        if (!rel)         c_d.dac = '0;
        else if (ddir_en) c_d.dac = ddir_val;
        else              c_d.dac = rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign dac_q = c_q.dac;
endmodule

// File: rtl/lut_dac_seq.sv
module lut_dac_seq #(
    parameter int CODE_W   = lds_pkg::CODE_W_DEF,
    parameter int ADDR_W   = lds_pkg::ADDR_W_DEF,
    parameter int AVG_LOG2 = lds_pkg::AVG_LOG2_DEF,
    parameter int NCH      = lds_pkg::NCH_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  adc_valid,
    input  logic [CODE_W-1:0]     adc_code,
    input  logic                  filt_off,
    input  logic [NCH-1:0]        tbl_dir_en,
    input  logic [NCH*ADDR_W-1:0] tbl_dir_addr,
    input  logic [NCH-1:0]        dac_dir_en,
    input  logic [NCH*CODE_W-1:0] dac_dir_val,
    output logic [NCH*ADDR_W-1:0] tbl_addr,
    input  logic [NCH*CODE_W-1:0] tbl_data,
    output logic [NCH*CODE_W-1:0] dac_code
);
    logic [ADDR_W-1:0] idx_q;
    logic              temp_ok;
    logic              rel_d, rel_q;

    lds_sampler #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .AVG_LOG2(AVG_LOG2)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .adc_valid (adc_valid),
        .adc_code  (adc_code),
        .filt_off  (filt_off),
        .idx_q     (idx_q),
        .ok_q      (temp_ok)
    );

    // release waits one cycle so the table read of the first index has landed
    always_comb rel_d = temp_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rel_q <= 1'b0;
        else        rel_q <= rel_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        lds_channel #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .rel       (rel_q),
            .adc_idx   (idx_q),
            .tdir_en   (tbl_dir_en[i]),
            .tdir_addr (tbl_dir_addr[i*ADDR_W +: ADDR_W]),
            .ddir_en   (dac_dir_en[i]),
            .ddir_val  (dac_dir_val[i*CODE_W +: CODE_W]),
            .rd_data   (tbl_data[i*CODE_W +: CODE_W]),
            .rd_addr   (tbl_addr[i*ADDR_W +: ADDR_W]),
            .dac_q     (dac_code[i*CODE_W +: CODE_W])
        );
    end
endmodule

// File: rtl/lds_chk.sv
module lds_chk #(
    parameter int CODE_W = lds_pkg::CODE_W_DEF,
    parameter int ADDR_W = lds_pkg::ADDR_W_DEF,
    parameter int NCH    = lds_pkg::NCH_DEF
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  adc_valid,
    input logic [CODE_W-1:0]     adc_code,
    input logic                  filt_off,
    input logic [NCH-1:0]        dac_dir_en,
    input logic [NCH*CODE_W-1:0] dac_dir_val,
    input logic [NCH*CODE_W-1:0] tbl_data,
    input logic [NCH*CODE_W-1:0] dac_code,
    input logic [ADDR_W-1:0]     idx_q,
    input logic                  temp_ok,
    input logic                  rel_q
);
    // R2
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_ok |-> ##2 (dac_code == '0));

    // R3
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_off && adc_valid) |=> temp_ok);

    // R5
    single_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_off && adc_valid) |=> (idx_q == $past(adc_code[CODE_W-1 -: ADDR_W])));

    // R10
    idle_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_valid |=> ($stable(idx_q) && $stable(temp_ok)));

    // R7
    direct_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_q && dac_dir_en[0]) |=> (dac_code[CODE_W-1:0] == $past(dac_dir_val[CODE_W-1:0])));

    // R8
    table_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_q && !dac_dir_en[0]) |=> (dac_code[CODE_W-1:0] == $past(tbl_data[CODE_W-1:0])));

    // R9
    table_ch1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_q && !dac_dir_en[1]) |=> (dac_code[2*CODE_W-1:CODE_W] == $past(tbl_data[2*CODE_W-1:CODE_W])));
endmodule

bind lut_dac_seq lds_chk #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_valid   (adc_valid),
    .adc_code    (adc_code),
    .filt_off    (filt_off),
    .dac_dir_en  (dac_dir_en),
    .dac_dir_val (dac_dir_val),
    .tbl_data    (tbl_data),
    .dac_code    (dac_code),
    .idx_q       (idx_q),
    .temp_ok     (temp_ok),
    .rel_q       (rel_q)
);

// File: tb/lut_dac_seq_test.sv
module lut_dac_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adc_valid = 1'b0;
    logic [7:0]  adc_code = '0;
    logic        filt_off = 1'b0;
    logic [1:0]  tbl_dir_en = '0;
    logic [11:0] tbl_dir_addr = '0;
    logic [1:0]  dac_dir_en = '0;
    logic [15:0] dac_dir_val = '0;
    logic [11:0] tbl_addr;
    logic [15:0] tbl_data = '0;
    logic [15:0] dac_code;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lut_dac_seq uut (
        .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_code(adc_code),
        .filt_off(filt_off), .tbl_dir_en(tbl_dir_en), .tbl_dir_addr(tbl_dir_addr),
        .dac_dir_en(dac_dir_en), .dac_dir_val(dac_dir_val), .tbl_addr(tbl_addr),
        .tbl_data(tbl_data), .dac_code(dac_code)
    );

    function automatic logic [7:0] entry(input int ch, input logic [5:0] a);
        return 8'((int'(a) * 37 + ch * 91 + 5) & 255);
    endfunction

    // table storage with one-cycle read latency
    always @(posedge clk) begin
        tbl_data[7:0]  <= entry(0, tbl_addr[5:0]);
        tbl_data[15:8] <= entry(1, tbl_addr[11:6]);
    end

    // reference model built from the requirements
    logic [5:0] m_idx;
    logic       m_ok, m_rel;
    int         m_acc, m_cnt;
    logic [7:0] m_dac0, m_dac1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idx <= '0; m_ok <= 1'b0; m_rel <= 1'b0; m_acc <= 0; m_cnt <= 0;
            m_dac0 <= '0; m_dac1 <= '0;
        end else begin
            if (adc_valid) begin
                if (filt_off) begin
                    m_idx <= adc_code[7:2]; m_ok <= 1'b1; m_acc <= 0; m_cnt <= 0;
                end else if (m_cnt == 3) begin
                    m_idx <= 6'(((m_acc + int'(adc_code)) / 4) >> 2);
                    m_ok <= 1'b1; m_acc <= 0; m_cnt <= 0;
                end else begin
                    m_acc <= m_acc + int'(adc_code); m_cnt <= m_cnt + 1;
                end
            end
            m_rel  <= m_ok;
            m_dac0 <= !m_rel ? 8'h00 : (dac_dir_en[0] ? dac_dir_val[7:0]  : tbl_data[7:0]);
            m_dac1 <= !m_rel ? 8'h00 : (dac_dir_en[1] ? dac_dir_val[15:8] : tbl_data[15:8]);
        end
    end

    task automatic cmp(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic model_check(input string r_addr, input string r_dac);
        cmp(r_addr, int'(tbl_addr[5:0]),  int'(tbl_dir_en[0] ? tbl_dir_addr[5:0]  : m_idx));
        cmp(r_addr, int'(tbl_addr[11:6]), int'(tbl_dir_en[1] ? tbl_dir_addr[11:6] : m_idx));
        cmp(r_dac,  int'(dac_code[7:0]),  int'(m_dac0));
        cmp(r_dac,  int'(dac_code[15:8]), int'(m_dac1));
    endtask

    task automatic sample(input logic [7:0] c);
        adc_code = c; adc_valid = 1'b1;
        tick();
        adc_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; adc_valid = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic random_run(input int cycles, input string r_dac);
        for (int k = 0; k < cycles; k++) begin
            adc_valid = ($urandom % 3) != 0;
            adc_code  = 8'($urandom);
            if (($urandom % 8) == 0) tbl_dir_en   = 2'($urandom);
            if (($urandom % 8) == 0) tbl_dir_addr = 12'($urandom);
            if (($urandom % 6) == 0) dac_dir_en   = 2'($urandom);
            if (($urandom % 4) == 0) dac_dir_val  = 16'($urandom);
            tick();
            model_check("R6", r_dac);
        end
        adc_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        tick();
        // R1: reset state
        cmp("R1", int'(dac_code), 0);
        tbl_dir_en = 2'b10; tbl_dir_addr = {6'd17, 6'd9};
        tick();
        cmp("R1", int'(tbl_addr), int'({6'd17, 6'd0}));
        rst_n = 1'b1;
        tick();
        cmp("R1", int'(dac_code), 0);
        tbl_dir_en = 2'b00;

        // R2/R4: averaging mode, direct values requested during hold
        filt_off = 1'b0;
        dac_dir_en = 2'b11; dac_dir_val = 16'h3CA5;
        sample(8'd40); sample(8'd80); sample(8'd120);
        tick(); tick(); tick();
        cmp("R2", int'(dac_code), 0);
        cmp("R4", int'(dac_code), 0);
        sample(8'd203);             // sum 443, mean 110 -> index 27
        tick();
        cmp("R4", int'(dac_code), 0);
        tick();
        cmp("R4", int'(dac_code), int'(16'h3CA5));
        cmp("R5", int'(tbl_addr[5:0]), 27);
        // R8: table path one cycle after the read
        dac_dir_en = 2'b00;
        tick(); tick();
        cmp("R8", int'(dac_code[7:0]),  int'(entry(0, 6'd27)));
        cmp("R8", int'(dac_code[15:8]), int'(entry(1, 6'd27)));
        random_run(400, "R5");

        // R3: single-sample mode
        do_reset();
        filt_off = 1'b1; dac_dir_en = 2'b00; tbl_dir_en = 2'b00;
        tick();
        cmp("R3", int'(dac_code), 0);
        sample(8'hC7);              // index 49
        tick();
        cmp("R3", int'(dac_code), 0);
        tick();
        cmp("R3", int'(dac_code[7:0]), int'(entry(0, 6'd49)));
        cmp("R5", int'(tbl_addr[11:6]), 49);
        // R10: codes without valid are ignored
        adc_code = 8'h04;
        tick(); tick(); tick();
        cmp("R10", int'(tbl_addr[5:0]), 49);
        cmp("R10", int'(dac_code[15:8]), int'(entry(1, 6'd49)));
        // R7: direct value one cycle later
        dac_dir_en = 2'b01; dac_dir_val = 16'h00E1;
        tick();
        cmp("R7", int'(dac_code[7:0]), int'(8'hE1));
        // R9: channel 1 unaffected; direct table address on channel 0 only
        cmp("R9", int'(dac_code[15:8]), int'(entry(1, 6'd49)));
        dac_dir_en = 2'b00; tbl_dir_en = 2'b01; tbl_dir_addr = {6'd3, 6'd63};
        tick();
        cmp("R6", int'(tbl_addr[5:0]), 63);
        cmp("R9", int'(tbl_addr[11:6]), 49);
        tick();
        cmp("R6", int'(dac_code[7:0]), int'(entry(0, 6'd63)));
        cmp("R9", int'(dac_code[15:8]), int'(entry(1, 6'd49)));
        random_run(400, "R7");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule